// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in an SDRAM controller's command path and produces the column address for every beat of a read or write burst. A one-cycle start pulse carries the starting column and the direction. The mode inputs select the burst length (1, 2, 4, 8 or the whole page), the wrap order (sequential or interleaved), the read latency (2 or 3 cycles) and whether writes are limited to a single beat. From the cycle after the start, the block issues one column per cycle, together with a beat-valid strobe and a final-beat strobe. For reads it also raises a read-data-valid strobe once per beat, delayed by the selected latency.

A precharge, given on the stop input, ends the burst at once. A new start on any cycle drops the current burst and begins the new one at its own column, which gives random column access. A full-page burst runs through the page in sequential order, wrapping modulo the page size (parameter `PAGE_COLS`, 256 or 512 columns), until a stop or a new start arrives.

The controller is built around three states. `ST_IDLE` means no burst is running. `ST_BURST` runs a fixed-length burst. `ST_PAGE` runs a full-page burst. The transitions are as follows:
- start: from any state to `ST_BURST`, or to `ST_PAGE` when full page is selected.
- done: from `ST_BURST` to `ST_IDLE` after the final beat.
- stop: from `ST_BURST` or `ST_PAGE` to `ST_IDLE`.
- step: stays in `ST_BURST` or `ST_PAGE` and advances the beat counter.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `beat_vld`, `beat_last` and `rd_data_vld` are low.
- R2: When `start` is sampled high on a clock edge, in the next cycle `beat_vld` is high and `col_out` equals the sampled `start_col`. Each following cycle of the burst shows the next beat.
- R3: The `len_code` field selects the burst length. The codes are: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats, 7 gives a full page, and 4, 5 and 6 give 1 beat. A fixed burst of L beats shows `beat_vld` high for exactly L cycles.
- R4: Sequential order (`order_il`=0) works as follows. For burst length L and start column c, beat i shows column c - (c mod L) + ((c mod L + i) mod L).
- R5: Interleaved order (`order_il`=1) works as follows. Beat i shows column c - (c mod L) + ((c mod L) XOR i).
- R6: A full-page burst always uses sequential order, whatever the value of `order_il`. Beat i shows (c + i) mod `PAGE_COLS`, and beats continue until a stop or a new start.
- R7: `beat_last` is high only on the final beat of a fixed-length burst. It is never high during a full-page burst.
- R8: When `stop` is sampled high and `start` is low on the same edge, `beat_vld` is low from the next cycle on.
- R9: When `start` is sampled high during a burst, the current burst is dropped and the new burst begins in the next cycle at its own column with its own settings. If `start` and `stop` are sampled high together, `start` wins.
- R10: `rd_data_vld` repeats, with a delay of 2 cycles (`cl_sel`=0) or 3 cycles (`cl_sel`=1), the `beat_vld` of read bursts only. Beats issued before a stop still produce their read strobe.
- R11: A write (`start_wr`=1) started while `single_wr`=1 is one beat long, whatever `len_code` is, and `beat_last` is high on that beat. Reads ignore `single_wr`.
- R12: `len_code`, `order_il`, `start_wr` and `single_wr` are sampled only when `start` is high. Changes during a burst do not change its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle read or write command |
| start_col | input | COL_W | Starting column of the burst |
| start_wr | input | 1 | 1 = write, 0 = read |
| len_code | input | 3 | Burst length code (see R3) |
| order_il | input | 1 | 1 = interleaved order, 0 = sequential order |
| cl_sel | input | 1 | Read latency: 0 = 2 cycles, 1 = 3 cycles |
| single_wr | input | 1 | Limits writes to one beat |
| stop | input | 1 | Precharge: ends the running burst |
| col_out | output | COL_W | Column address of the current beat |
| beat_vld | output | 1 | A beat is issued this cycle |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| rd_data_vld | output | 1 | Read data expected this cycle |

## Verification
The read-latency assertion assumes that `cl_sel` does not change while read strobes are still in the delay line. The bench therefore changes `cl_sel` only between bursts, after at least three idle cycles. The assertions also assume that `start` and `stop` are single-cycle strobes driven away from the clock edge. The bench drives all inputs on the falling edge and sweeps every start column of a 256-column page, for every fixed length and both orders. The length and order settings are held steady inside each sweep, except in the directed test for R12, which changes them on purpose.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } cg_state_t;

    localparam logic [2:0] LEN_PAGE = 3'd7;

    // log2 of the fixed burst length for a length code
    function automatic logic [1:0] len_log2(input logic [2:0] code);
        unique case (code)
            3'd1:    return 2'd1;
            3'd2:    return 2'd2;
            3'd3:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/sdram_colgen_addr.sv
module sdram_colgen_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [1:0]       len_lg,
    input  logic             il,
    input  logic             full,
    output logic [COL_W-1:0] col,
    output logic [COL_W-1:0] mask
);
    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] il_off;

    always_comb begin
        mask    = (COL_W'(1) << len_lg) - COL_W'(1);
        seq_off = (base + cnt) & mask;
        il_off  = (base ^ cnt) & mask;
        if (full)
            col = base + cnt;
        else if (il)
            col = (base & ~mask) | il_off;
        else
            col = (base & ~mask) | seq_off;
    end
endmodule

// File: rtl/sdram_colgen_rdpipe.sv
module sdram_colgen_rdpipe #(
    parameter int MAX_CL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic cl_sel,
    output logic dout
);
    logic [MAX_CL-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr[0] <= din;
            for (int k = 1; k < MAX_CL; k++)
                sr[k] <= sr[k-1];
        end
    end

    always_comb dout = cl_sel ? sr[2] : sr[1];

    // R10
    rd_lat2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout && !cl_sel && $past(!cl_sel)) |-> $past(din, 2));
    // R10
    rd_lat3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout && cl_sel && $past(cl_sel) && $past(cl_sel, 2)) |-> $past(din, 3));
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_colgen_pkg::*;
#(
    parameter int PAGE_COLS = 256,
    parameter int MAX_CL    = 3,
    localparam int COL_W    = $clog2(PAGE_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic [2:0]       len_code,
    input  logic             order_il,
    input  logic             cl_sel,
    input  logic             single_wr,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             beat_vld,
    output logic             beat_last,
    output logic             rd_data_vld
);
    cg_state_t        state;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] cnt_q;
    logic [1:0]       lg_q;
    logic             il_q;
    logic             wr_q;
    logic [COL_W-1:0] last_idx;
    logic [COL_W-1:0] mask;
    logic             one_beat;
    logic             rd_beat;

    // one-beat write overrides the programmed length
    always_comb one_beat = start_wr && single_wr;

    always_comb last_idx = (COL_W'(1) << lg_q) - COL_W'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
            lg_q   <= '0;
            il_q   <= 1'b0;
            wr_q   <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            cnt_q  <= '0;
            wr_q   <= start_wr;
            il_q   <= order_il;
            lg_q   <= one_beat ? 2'd0 : len_log2(len_code);
            state  <= (len_code == LEN_PAGE && !one_beat) ? ST_PAGE : ST_BURST;
        end else if (stop) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_BURST: begin
                    if (cnt_q == last_idx) state <= ST_IDLE;
                    else                   cnt_q <= cnt_q + COL_W'(1);
                end
                ST_PAGE: cnt_q <= cnt_q + COL_W'(1);
                default: state <= ST_IDLE;
            endcase
        end
    end

    sdram_colgen_addr #(.COL_W(COL_W)) u_addr (
        .base   (base_q),
        .cnt    (cnt_q),
        .len_lg (lg_q),
        .il     (il_q),
        .full   (state == ST_PAGE),
        .col    (col_out),
        .mask   (mask)
    );

    // outputs
    always_comb begin
        beat_vld  = 1'b0;
        beat_last = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_BURST: begin
                beat_vld  = 1'b1;
                beat_last = (cnt_q == last_idx);
            end
            ST_PAGE: beat_vld = 1'b1;
            default: ;
        endcase
        rd_beat = beat_vld && !wr_q;
    end

    sdram_colgen_rdpipe #(.MAX_CL(MAX_CL)) u_rdpipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (rd_beat),
        .cl_sel (cl_sel),
        .dout   (rd_data_vld)
    );

    // R2
    start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_vld && col_out == $past(start_col)));
    // R7
    last_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> (beat_vld && state == ST_BURST));
    // R8
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !beat_vld);
    // R3
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start) |=> !beat_vld);
    // R4
    wrap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && $past(state == ST_BURST) && !$past(start))
        |-> (((col_out ^ $past(col_out)) & ~mask) == '0));
endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
    localparam int PAGE_COLS = 256;
    localparam int COL_W     = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             start_wr = 1'b0;
    logic [2:0]       len_code = '0;
    logic             order_il = 1'b0;
    logic             cl_sel = 1'b0;
    logic             single_wr = 1'b0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             beat_vld;
    logic             beat_last;
    logic             rd_data_vld;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sdram_burst_colgen #(.PAGE_COLS(PAGE_COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .start_wr(start_wr), .len_code(len_code), .order_il(order_il),
        .cl_sel(cl_sel), .single_wr(single_wr), .stop(stop),
        .col_out(col_out), .beat_vld(beat_vld), .beat_last(beat_last),
        .rd_data_vld(rd_data_vld)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int c, input int len, input int il, input int i);
        int lo = c % len;
        if (il != 0) return c - lo + (lo ^ i);
        return c - lo + ((lo + i) % len);
    endfunction

    // one fixed burst, checked cycle by cycle from start to drain
    task automatic run_fixed(input int c, input int code, input int il, input int wr,
                             input int sw, input int cl, input string otag);
        int len;
        int lat;
        if (wr != 0 && sw != 0)  len = 1;
        else if (code <= 3)      len = 1 << code;
        else                     len = 1;
        lat = cl + 2;
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(c); len_code = 3'(code);
        order_il = il[0]; start_wr = wr[0]; single_wr = sw[0]; cl_sel = cl[0];
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len + 4; i++) begin
            check("R3 beat_vld", int'(beat_vld), (i < len) ? 1 : 0);
            if (i < len) check(otag, int'(col_out), exp_col(c, len, il, i));
            check("R7 beat_last", int'(beat_last), (i == len - 1) ? 1 : 0);
            check("R10 rd_data_vld", int'(rd_data_vld),
                  (wr == 0 && i >= lat && i < lat + len) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 beat_vld", int'(beat_vld), 0);
        check("R1 rd_data_vld", int'(rd_data_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 beat_last", int'(beat_last), 0);
        check("R1 beat_vld after release", int'(beat_vld), 0);

        // R2 R3 R4 R5 R7 R10: sweep all columns, fixed lengths, both orders
        for (int code = 0; code < 4; code++)
            for (int il = 0; il < 2; il++)
                for (int c = 0; c < PAGE_COLS; c++)
                    run_fixed(c, code, il, c & 1, 0, (c >> 1) & 1,
                              il ? "R5 col" : "R4 col");

        // R3 reserved codes give one beat
        for (int code = 4; code < 7; code++) run_fixed(37, code, 0, 0, 0, 0, "R3 col");

        // R11 single write, and read ignoring the one-beat write setting
        run_fixed(10, 3, 0, 1, 1, 0, "R11 col");
        run_fixed(10, 3, 1, 0, 1, 1, "R11 read col");
        single_wr = 1'b0;

        // R6 full page with wrap; interleave flag ignored; R8 stop; R10 drain
        @(negedge clk);
        start = 1'b1; start_col = 8'd250; len_code = 3'd7; order_il = 1'b1;
        start_wr = 1'b0; cl_sel = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 30; i++) begin
            check("R6 col", int'(col_out), (250 + i) % PAGE_COLS);
            check("R6 beat_vld", int'(beat_vld), 1);
            check("R7 no last in page", int'(beat_last), 0);
            check("R10 page rd", int'(rd_data_vld), (i >= 3) ? 1 : 0);
            if (i == 29) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        for (int i = 30; i < 35; i++) begin
            check("R8 page stopped", int'(beat_vld), 0);
            check("R10 drain after stop", int'(rd_data_vld), (i < 33) ? 1 : 0);
            @(negedge clk);
        end

        // R8 stop in the middle of a fixed burst
        cl_sel = 1'b0;
        @(negedge clk);
        start = 1'b1; start_col = 8'd5; len_code = 3'd3; order_il = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check("R8 pre-stop col", int'(col_out), 5 + i);
            if (i == 2) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        check("R8 beat_vld", int'(beat_vld), 0);
        @(negedge clk);
        check("R8 beat_vld stays low", int'(beat_vld), 0);
        repeat (3) @(negedge clk);

        // R9 restart mid burst, with stop on the same edge
        start = 1'b1; start_col = 8'd16; len_code = 3'd3;
        @(negedge clk);
        start = 1'b0;
        check("R9 first col", int'(col_out), 16);
        @(negedge clk);
        check("R9 second col", int'(col_out), 17);
        start = 1'b1; stop = 1'b1; start_col = 8'd101; len_code = 3'd1; start_wr = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check("R9 restart col", int'(col_out), 101);
        check("R9 restart vld", int'(beat_vld), 1);
        @(negedge clk);
        check("R9 second beat col", int'(col_out), 100);
        check("R9 last", int'(beat_last), 1);
        @(negedge clk);
        check("R9 end", int'(beat_vld), 0);
        repeat (3) @(negedge clk);

        // R12 mode changes during a burst are ignored
        start = 1'b1; start_col = 8'd6; len_code = 3'd2; order_il = 1'b0; start_wr = 1'b0;
        @(negedge clk);
        start = 1'b0; len_code = 3'd0; order_il = 1'b1; start_wr = 1'b1; single_wr = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check("R12 col", int'(col_out), 4 + ((2 + i) % 4));
            check("R12 vld", int'(beat_vld), 1);
            @(negedge clk);
        end
        check("R12 end", int'(beat_vld), 0);
        check("R12 read kept", int'(rd_data_vld), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule